// File: doc/BRIEF.md
# Guarded Multi-Bus Move Interconnect

This block is the transport network and move decoder of a small processor whose only instruction is a data move. Each cycle it receives one instruction word holding one move slot per bus plus a long-immediate field. Every slot names a guard, a source and a destination. The source is either a short immediate held in the slot itself or a socket number. The destination is a socket number. All buses act in parallel. A slot whose guard fails is dropped as if it were absent.

Readable sockets are the general registers, the function unit result registers and the long-immediate field of the instruction register. Writable sockets are the general registers, the operand and trigger registers of each function unit, the 1-bit predicate registers and the program counter. Function unit registers live outside the block. The block drives a write strobe and data to them in the cycle of the move, and they capture at the following clock edge. The general registers, predicates and program counter are held inside the block. A jump is a move into the program counter socket, and a guarded jump is a conditional branch.

Top module: `move_fabric`

## Requirements
- R1: Bus k takes its slot from `instr_i[k*15 +: 15]`. From MSB to LSB a slot holds: guard enable (bit 14), guard invert (bit 13), predicate index (bits 12:11), immediate flag (bit 10), source (bits 9:5) and destination (bits 4:0). All four buses execute in the same cycle.
- R2: A guard with the enable bit clear always passes. With the enable bit set, the guard passes when the indexed predicate XOR the invert bit is 1. A slot whose guard fails causes no strobe, no register write and no conflict.
- R3: With the immediate flag set, the source value is the 5-bit source field zero-extended. Otherwise source 0..7 reads a general register, 8..11 reads function unit result 0..3, 12 reads the long immediate, and any other number reads zero.
- R4: Destinations are numbered as follows. 0..7 is a general register, 8..11 is the operand register of unit 0..3, and 12..15 is the trigger register of unit 0..3. 16..19 is predicate 0..3, which takes bit 0 of the moved value, and 20 is the program counter. Any other number discards the move. A unit's strobe and data are driven in the same cycle as the move.
- R5: Writes to general registers, predicates and the program counter take effect at the clock edge that ends the move's cycle. A read of a register in the same cycle as a write to it returns the old value.
- R6: With no active move to socket 20, the program counter is one greater in the next cycle. With such a move, the program counter takes the low 16 bits of the moved value.
- R7: When two or more active moves target the same destination, the lowest-numbered bus wins and `conflict_o` is 1 in the next cycle. Otherwise `conflict_o` is 0 in the next cycle.
- R8: Reset (active low) clears the program counter, all predicates, all general registers and `conflict_o`.
- R9: A predicate written from a function unit result can guard moves in the next cycle.
- R10: The long immediate is `instr_i[60 +: 32]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 92 | Four move slots and the long-immediate field |
| fu_res_i | input | 128 | Result registers of function units 0..3, 32 bits each |
| fu_op_we_o | output | 4 | Operand register write strobe per unit |
| fu_op_data_o | output | 128 | Operand register write data per unit |
| fu_tr_we_o | output | 4 | Trigger register write strobe per unit |
| fu_tr_data_o | output | 128 | Trigger register write data per unit |
| pred_o | output | 4 | Predicate register bank |
| pc_o | output | 16 | Program counter |
| conflict_o | output | 1 | Destination conflict seen in the previous cycle |

## Verification
Function unit strobes and data are combinational in the move's cycle. Predicate, program counter and conflict results are due one clock later. General register writes show up only when a later move reads the register, one cycle after the writing move at the earliest. Each expected item in the scoreboard carries the cycle it is due in. Items for strobes are due in the issuing cycle, and items for registered state are due in the cycle after. The monitor samples at the falling edge and compares only the items due in that cycle. Any item left unchecked at the end counts as a failure.

// File: rtl/move_pkg.sv
package move_pkg;

    typedef enum logic [2:0] {
        SRC_IMM,
        SRC_GPR,
        SRC_RES,
        SRC_LIMM,
        SRC_ZERO
    } src_kind_e;

    function automatic logic guard_pass(input logic en, input logic inv, input logic pbit);
        return !en || (pbit ^ inv);
    endfunction

endpackage

// File: rtl/move_slot_dec.sv
module move_slot_dec
    import move_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NGPR  = 8,
    parameter int NFU   = 4,
    parameter int NPRED = 4,
    parameter int NDST  = 21,
    parameter int SKW   = 5,
    parameter int PIW   = 2,
    parameter int SLW   = 15
) (
    input  logic [SLW-1:0]      slot_i,
    input  logic [NGPR*DW-1:0]  gpr_i,
    input  logic [NFU*DW-1:0]   res_i,
    input  logic [DW-1:0]       limm_i,
    input  logic [NPRED-1:0]    pred_i,
    output logic                act_o,
    output logic [SKW-1:0]      dst_o,
    output logic [DW-1:0]       data_o
);
    localparam int RES_BASE = NGPR;
    localparam int LIMM_ID  = NGPR + NFU;

    logic           g_en;
    logic           g_inv;
    logic [PIW-1:0] g_idx;
    logic           is_imm;
    logic [SKW-1:0] src;
    logic           pbit;
    src_kind_e      kind;

    assign dst_o  = slot_i[SKW-1:0];
    assign src    = slot_i[2*SKW-1:SKW];
    assign is_imm = slot_i[2*SKW];
    assign g_idx  = slot_i[2*SKW+PIW:2*SKW+1];
    assign g_inv  = slot_i[2*SKW+PIW+1];
    assign g_en   = slot_i[2*SKW+PIW+2];

    always_comb begin
        pbit = 1'b0;
        for (int p = 0; p < NPRED; p++) begin
            if (g_idx == PIW'(p)) pbit = pred_i[p];
        end
    end

    assign act_o = guard_pass(g_en, g_inv, pbit) && (dst_o < SKW'(NDST));

    always_comb begin
        if (is_imm)                                    kind = SRC_IMM;
        else if (src < SKW'(RES_BASE))                 kind = SRC_GPR;
        else if (src < SKW'(LIMM_ID))                  kind = SRC_RES;
        else if (src == SKW'(LIMM_ID))                 kind = SRC_LIMM;
        else                                           kind = SRC_ZERO;
    end

    always_comb begin
        data_o = '0;
        unique case (kind)
            SRC_IMM:  data_o = {{(DW-SKW){1'b0}}, src};
            SRC_GPR: begin
                for (int g = 0; g < NGPR; g++) begin
                    if (src == SKW'(g)) data_o = gpr_i[g*DW +: DW];
                end
            end
            SRC_RES: begin
                for (int f = 0; f < NFU; f++) begin
                    if (src == SKW'(RES_BASE + f)) data_o = res_i[f*DW +: DW];
                end
            end
            SRC_LIMM: data_o = limm_i;
            default:  data_o = '0;
        endcase
    end
endmodule

// File: rtl/move_arb.sv
module move_arb #(
    parameter int NBUS = 4,
    parameter int NDST = 21,
    parameter int DW   = 32,
    parameter int SKW  = 5
) (
    input  logic [NBUS-1:0]     act_i,
    input  logic [NBUS*SKW-1:0] dst_i,
    input  logic [NBUS*DW-1:0]  data_i,
    output logic [NDST-1:0]     we_o,
    output logic [NDST*DW-1:0]  data_o,
    output logic                conflict_o
);
    always_comb begin
        int hits;
        we_o       = '0;
        data_o     = '0;
        conflict_o = 1'b0;
        for (int d = 0; d < NDST; d++) begin
            hits = 0;
            for (int b = NBUS - 1; b >= 0; b--) begin
                if (act_i[b] && (dst_i[b*SKW +: SKW] == SKW'(d))) begin
                    hits = hits + 1;
                    we_o[d] = 1'b1;
                    data_o[d*DW +: DW] = data_i[b*DW +: DW];
                end
            end
            if (hits > 1) conflict_o = 1'b1;
        end
    end
endmodule

// File: rtl/move_fabric.sv
module move_fabric #(
    parameter int NBUS  = 4,
    parameter int DW    = 32,
    parameter int NGPR  = 8,
    parameter int NFU   = 4,
    parameter int NPRED = 4,
    parameter int PCW   = 16,
    localparam int NDST = NGPR + 2*NFU + NPRED + 1,
    localparam int SKW  = $clog2(NDST + 1),
    localparam int PIW  = (NPRED > 1) ? $clog2(NPRED) : 1,
    localparam int SLW  = 2*SKW + PIW + 3,
    localparam int IW   = NBUS*SLW + DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     instr_i,
    input  logic [NFU*DW-1:0] fu_res_i,
    output logic [NFU-1:0]    fu_op_we_o,
    output logic [NFU*DW-1:0] fu_op_data_o,
    output logic [NFU-1:0]    fu_tr_we_o,
    output logic [NFU*DW-1:0] fu_tr_data_o,
    output logic [NPRED-1:0]  pred_o,
    output logic [PCW-1:0]    pc_o,
    output logic              conflict_o
);
    localparam int OPR_BASE = NGPR;
    localparam int TRG_BASE = NGPR + NFU;
    localparam int PRD_BASE = NGPR + 2*NFU;
    localparam int PC_ID    = PRD_BASE + NPRED;

    typedef struct packed {
        logic [NGPR-1:0][DW-1:0] gpr;
        logic [NPRED-1:0]        pred;
        logic [PCW-1:0]          pc;
        logic                    conflict;
    } state_t;

    state_t st_q, st_d;

    logic [NGPR*DW-1:0]  gpr_flat;
    logic [DW-1:0]       limm;
    logic [NBUS-1:0]     act;
    logic [NBUS*SKW-1:0] dst;
    logic [NBUS*DW-1:0]  bus_data;
    logic [NDST-1:0]     dst_we;
    logic [NDST*DW-1:0]  dst_data;
    logic                conf_c;
    logic                pc_wr;
    logic [NPRED-1:0]    pred_wr;

    assign gpr_flat = st_q.gpr;
    assign limm     = instr_i[NBUS*SLW +: DW];

    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        move_slot_dec #(
            .DW(DW), .NGPR(NGPR), .NFU(NFU), .NPRED(NPRED),
            .NDST(NDST), .SKW(SKW), .PIW(PIW), .SLW(SLW)
        ) u_dec (
            .slot_i (instr_i[b*SLW +: SLW]),
            .gpr_i  (gpr_flat),
            .res_i  (fu_res_i),
            .limm_i (limm),
            .pred_i (st_q.pred),
            .act_o  (act[b]),
            .dst_o  (dst[b*SKW +: SKW]),
            .data_o (bus_data[b*DW +: DW])
        );
    end

    move_arb #(.NBUS(NBUS), .NDST(NDST), .DW(DW), .SKW(SKW)) u_arb (
        .act_i      (act),
        .dst_i      (dst),
        .data_i     (bus_data),
        .we_o       (dst_we),
        .data_o     (dst_data),
        .conflict_o (conf_c)
    );

    for (genvar f = 0; f < NFU; f++) begin : g_fu
        assign fu_op_we_o[f]              = dst_we[OPR_BASE+f];
        assign fu_op_data_o[f*DW +: DW]   = dst_data[(OPR_BASE+f)*DW +: DW];
        assign fu_tr_we_o[f]              = dst_we[TRG_BASE+f];
        assign fu_tr_data_o[f*DW +: DW]   = dst_data[(TRG_BASE+f)*DW +: DW];
    end

    assign pc_wr   = dst_we[PC_ID];
    assign pred_wr = dst_we[PRD_BASE +: NPRED];

    always_comb begin
        st_d          = st_q;
        st_d.conflict = conf_c;
        st_d.pc       = st_q.pc + PCW'(1);
        for (int g = 0; g < NGPR; g++) begin
            if (dst_we[g]) st_d.gpr[g] = dst_data[g*DW +: DW];
        end
        for (int p = 0; p < NPRED; p++) begin
            if (pred_wr[p]) st_d.pred[p] = dst_data[(PRD_BASE+p)*DW];
        end
        if (pc_wr) st_d.pc = dst_data[PC_ID*DW +: PCW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pred_o     = st_q.pred;
    assign pc_o       = st_q.pc;
    assign conflict_o = st_q.conflict;
endmodule

// File: rtl/move_fabric_chk.sv
module move_fabric_chk #(
    parameter int NBUS  = 4,
    parameter int DW    = 32,
    parameter int NGPR  = 8,
    parameter int NFU   = 4,
    parameter int NPRED = 4,
    parameter int PCW   = 16,
    parameter int NDST  = 21,
    parameter int SKW   = 5,
    parameter int SLW   = 15,
    parameter int IW    = 92
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IW-1:0]     instr_i,
    input logic [NFU-1:0]    fu_op_we_o,
    input logic [NFU*DW-1:0] fu_op_data_o,
    input logic [NFU-1:0]    fu_tr_we_o,
    input logic [NPRED-1:0]  pred_o,
    input logic [PCW-1:0]    pc_o,
    input logic              conflict_o,
    input logic              pc_wr,
    input logic [NPRED-1:0]  pred_wr
);
    logic           all_idle;
    logic [SLW-1:0] s0;
    logic           s0_free_imm;
    logic [SKW-1:0] s0_dst;
    logic [SKW-1:0] s0_src;

    always_comb begin
        all_idle = 1'b1;
        for (int b = 0; b < NBUS; b++) begin
            if (instr_i[b*SLW +: SKW] < SKW'(NDST)) all_idle = 1'b0;
        end
    end

    assign s0          = instr_i[SLW-1:0];
    assign s0_dst      = s0[SKW-1:0];
    assign s0_src      = s0[2*SKW-1:SKW];
    assign s0_free_imm = !s0[SLW-1] && s0[2*SKW];

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_wr |=> pc_o == $past(pc_o) + PCW'(1)) else $error("pc step");            // R6

    AST_PRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_wr == '0) |=> $stable(pred_o)) else $error("pred hold");              // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        all_idle |-> (fu_op_we_o == '0) && (fu_tr_we_o == '0)) else $error("idle"); // R4

    AST_IDLE_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        all_idle |=> !conflict_o) else $error("idle conflict");                      // R7

    for (genvar f = 0; f < NFU; f++) begin : g_bus0
        AST_BUS0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (s0_free_imm && s0_dst == SKW'(NGPR + f)) |->
                fu_op_we_o[f] && fu_op_data_o[f*DW +: DW] == {{(DW-SKW){1'b0}}, s0_src})
            else $error("bus0 priority");                                             // R7
    end
endmodule

bind move_fabric move_fabric_chk #(
    .NBUS(NBUS), .DW(DW), .NGPR(NGPR), .NFU(NFU), .NPRED(NPRED), .PCW(PCW),
    .NDST(NDST), .SKW(SKW), .SLW(SLW), .IW(IW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_i      (instr_i),
    .fu_op_we_o   (fu_op_we_o),
    .fu_op_data_o (fu_op_data_o),
    .fu_tr_we_o   (fu_tr_we_o),
    .pred_o       (pred_o),
    .pc_o         (pc_o),
    .conflict_o   (conflict_o),
    .pc_wr        (pc_wr),
    .pred_wr      (pred_wr)
);

// File: tb/move_fabric_tb.sv
`timescale 1ns/1ps
module move_fabric_tb;
    localparam int K_PC = 0, K_PRED = 1, K_CONF = 2, K_OPWE = 3, K_OPD = 4, K_TRWE = 5, K_TRD = 6;

    typedef struct {
        int          due;
        int          kind;
        int          idx;
        logic [31:0] val;
        string       rq;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [91:0]  ins;
    logic [127:0] fu_res;
    logic [3:0]   op_we, tr_we, pred;
    logic [127:0] op_d, tr_d;
    logic [15:0]  pc;
    logic         conf;

    int    cyc = 0;
    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    logic [15:0] exp_pc = '0;
    item_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    move_fabric u_dut (
        .clk(clk), .rst_n(rst_n), .instr_i(ins), .fu_res_i(fu_res),
        .fu_op_we_o(op_we), .fu_op_data_o(op_d), .fu_tr_we_o(tr_we), .fu_tr_data_o(tr_d),
        .pred_o(pred), .pc_o(pc), .conflict_o(conf)
    );

    function automatic logic [14:0] mk(input logic en, input logic inv, input logic [1:0] pi,
                                       input logic imm, input logic [4:0] src, input logic [4:0] dst);
        return {en, inv, pi, imm, src, dst};
    endfunction

    task automatic clr();
        for (int b = 0; b < 4; b++) ins[b*15 +: 15] = mk(0, 0, 0, 0, 0, 5'd31);
        ins[60 +: 32] = '0;
    endtask

    task automatic put(input int b, input logic [14:0] s);
        ins[b*15 +: 15] = s;
    endtask

    task automatic ex(input int off, input int kind, input int idx, input logic [31:0] v, input string rq);
        item_t it;
        it.due = cyc + off; it.kind = kind; it.idx = idx; it.val = v; it.rq = rq;
        sb.push_back(it);
    endtask

    task automatic step(input bit jmp, input logic [15:0] tgt);
        exp_pc = jmp ? tgt : exp_pc + 16'd1;
        ex(1, K_PC, 0, {16'd0, exp_pc}, "R6");
        @(posedge clk);
        #1;
        clr();
    endtask

    function automatic logic [31:0] actual(input item_t it);
        case (it.kind)
            K_PC:    return {16'd0, pc};
            K_PRED:  return {28'd0, pred};
            K_CONF:  return {31'd0, conf};
            K_OPWE:  return {31'd0, op_we[it.idx]};
            K_OPD:   return op_d[it.idx*32 +: 32];
            K_TRWE:  return {31'd0, tr_we[it.idx]};
            default: return tr_d[it.idx*32 +: 32];
        endcase
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].due == cyc) begin
                    logic [31:0] a;
                    a = actual(sb[i]);
                    checks++;
                    if (a !== sb[i].val) begin
                        errors++;
                        $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                                 sb[i].rq, sb[i].kind, sb[i].idx, a, sb[i].val);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        fu_res = {32'h0000_0103, 32'h0000_0102, 32'h0000_0101, 32'h0000_0100};
        clr();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8 reset state
        ex(0, K_PC, 0, 0, "R8"); ex(0, K_PRED, 0, 0, "R8"); ex(0, K_CONF, 0, 0, "R8");
        ex(0, K_OPWE, 0, 0, "R8");
        step(0, 0);

        // R1 four buses at once; R8 GPR reset; R3/R4 immediate to trigger
        put(0, mk(0, 0, 0, 0, 5'd5, 5'd8));
        put(1, mk(0, 0, 0, 1, 5'd7, 5'd3));
        put(2, mk(0, 0, 0, 1, 5'd9, 5'd13));
        ex(0, K_OPWE, 0, 1, "R1"); ex(0, K_OPD, 0, 0, "R8");
        ex(0, K_TRWE, 1, 1, "R4"); ex(0, K_TRD, 1, 9, "R3");
        step(0, 0);

        // R5 old value on same-cycle read, new value after the edge
        put(0, mk(0, 0, 0, 0, 5'd3, 5'd13));
        put(1, mk(0, 0, 0, 0, 5'd3, 5'd10));
        put(3, mk(0, 0, 0, 1, 5'd20, 5'd3));
        ex(0, K_TRD, 1, 7, "R5"); ex(0, K_OPD, 2, 7, "R5");
        step(0, 0);

        // R5 new value; R3 result source; R10 long immediate; R3 max short immediate
        put(0, mk(0, 0, 0, 0, 5'd3, 5'd10));
        put(1, mk(0, 0, 0, 0, 5'd10, 5'd15));
        put(2, mk(0, 0, 0, 0, 5'd12, 5'd11));
        put(3, mk(0, 0, 0, 1, 5'd31, 5'd9));
        ins[60 +: 32] = 32'hDEAD_BEEF;
        ex(0, K_OPD, 2, 20, "R5"); ex(0, K_TRD, 3, 32'h102, "R3");
        ex(0, K_OPD, 3, 32'hDEAD_BEEF, "R10"); ex(0, K_OPD, 1, 31, "R3");
        step(0, 0);

        // R9 predicate from result; R4 bit 0 only; R2 false guard squashed
        put(0, mk(0, 0, 0, 0, 5'd11, 5'd17));
        put(1, mk(0, 0, 0, 1, 5'd1, 5'd18));
        put(2, mk(0, 0, 0, 1, 5'd2, 5'd16));
        put(3, mk(1, 0, 2'd1, 1, 5'd5, 5'd8));
        ex(0, K_OPWE, 0, 0, "R2"); ex(1, K_PRED, 0, 4'b0110, "R9");
        step(0, 0);

        // R9 guard on new predicate; R2 false, inverted, squashed predicate write
        put(0, mk(1, 0, 2'd1, 1, 5'd5, 5'd8));
        put(1, mk(1, 0, 2'd0, 1, 5'd6, 5'd9));
        put(2, mk(1, 1, 2'd0, 1, 5'd7, 5'd14));
        put(3, mk(1, 0, 2'd0, 1, 5'd1, 5'd19));
        ex(0, K_OPWE, 0, 1, "R9"); ex(0, K_OPD, 0, 5, "R9");
        ex(0, K_OPWE, 1, 0, "R2"); ex(0, K_TRWE, 2, 1, "R2"); ex(0, K_TRD, 2, 7, "R2");
        ex(1, K_PRED, 0, 4'b0110, "R2");
        step(0, 0);

        // R6 jump; R7 squashed duplicate raises no conflict
        put(0, mk(0, 0, 0, 1, 5'd17, 5'd20));
        put(1, mk(1, 0, 2'd0, 1, 5'd3, 5'd20));
        ex(1, K_CONF, 0, 0, "R7");
        step(1, 16'd17);

        // R6 conditional jump taken
        put(0, mk(1, 0, 2'd2, 1, 5'd25, 5'd20));
        step(1, 16'd25);

        // R7 conflicts, lowest bus wins
        put(0, mk(0, 0, 0, 1, 5'd3, 5'd8));
        put(1, mk(0, 0, 0, 1, 5'd11, 5'd6));
        put(2, mk(0, 0, 0, 1, 5'd5, 5'd8));
        put(3, mk(0, 0, 0, 1, 5'd12, 5'd6));
        ex(0, K_OPD, 0, 3, "R7"); ex(1, K_CONF, 0, 1, "R7");
        step(0, 0);

        put(0, mk(0, 0, 0, 0, 5'd6, 5'd9));
        ex(0, K_OPD, 1, 11, "R7"); ex(1, K_CONF, 0, 0, "R7");
        step(0, 0);

        // R3 unmapped source reads zero; R4 unmapped destination discarded
        put(0, mk(0, 0, 0, 0, 5'd13, 5'd8));
        put(1, mk(0, 0, 0, 1, 5'd4, 5'd25));
        ex(0, K_OPD, 0, 0, "R3"); ex(0, K_OPWE, 1, 0, "R4");
        ex(0, K_TRWE, 0, 0, "R4"); ex(0, K_TRWE, 3, 0, "R4");
        step(0, 0);

        // R9 predicate cleared from a result with bit 0 clear
        put(0, mk(0, 0, 0, 0, 5'd10, 5'd18));
        ex(1, K_PRED, 0, 4'b0010, "R9");
        step(0, 0);

        repeat (3) @(posedge clk);
        #1;
        if (sb.size() != 0) begin
            errors += sb.size();
            $display("FAIL scoreboard items left=%0d expected=0", sb.size());
        end
        finish_run();
    end
endmodule